// File: doc/BRIEF.md
# Staged Module Power State Sequencer

This block keeps a 2-bit power state for each of a set of peripheral modules and drives each module's clock enable and reset from that state. Software writes a target state into each module's control word over a small word-addressed register bus. Those writes are only staged. Nothing happens to any module until software writes the commit command. The commit then walks the modules that need to change and moves them one by one.

A commit takes a copy of every staged target. The engine then finds the lowest-numbered module whose current state differs from its copied target. It spends a fixed number of cycles on that module and then updates the module's state. It repeats this until no module differs. A busy flag is set for the whole commit, and the engine ignores further commit commands while the flag is set. Each control word also holds a local reset bit, which drives a per-module output directly, whatever the power state.

Register words, by word address: 0 is the command word, 1 is the busy status, 2+i is the control word of module i, and 2+N_MOD+i is the state word of module i. Reads are combinational from the address.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: States are encoded as follows: 0 = reset-and-off, 1 = clocked-in-reset, 2 = off, 3 = on. Module i's current state reads at bits [1:0] of word 2+N_MOD+i. Its staged target reads and writes at bits [1:0] of word 2+i.
- R2: Writing a control word leaves every module's current state and outputs unchanged until a commit is issued.
- R3: The targets of several modules staged before one commit are all applied by that commit. When busy returns to 0, every module's state equals its staged target.
- R4: A write to word 0 with bit 0 set, while the block is idle, sets the busy flag (bit 0 of word 1) from the next cycle.
- R5: The busy flag stays at 1 until every module has reached its committed target.
- R6: A commit written while busy is ignored. A target written while busy is only staged, and the next commit applies it.
- R7: Bit 4 of a control word drives that module's local reset output (1 = asserted). Writing it does not change the power state.
- R8: Modules change one at a time, in ascending index order. Each change takes XFER_CYC cycles. Busy lasts 1 + XFER_CYC*k cycles for k changing modules.
- R9: Module outputs follow the state as follows: on gives clock on and reset off. Off gives clock off and reset off. Clocked-in-reset gives clock on and reset on. Reset-and-off gives clock off and reset on.
- R10: After reset, all states, all targets and all local reset bits are 0, and busy is 0.
- R11: A module whose target equals its state at commit time costs no transition cycles.
- R12: Word 0 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module reset from power state |
| mod_lrst | output | N_MOD | Per-module local reset from control bit 4 |

## Verification
The bench builds the block with N_MOD=4 and XFER_CYC=3. With three cycles per change, the exact cycle at which each module's outputs flip, and the exact busy length, can be checked against 1 + 3*k for several values of k. Four modules are enough for a single commit to move modules that are not adjacent, to skip modules in between, and to set all four encodings at once. Commands and targets written during a commit are checked to be held back for the following commit.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_RST_OFF = 2'd0,
        PS_RST_CLK = 2'd1,
        PS_OFF     = 2'd2,
        PS_ON      = 2'd3
    } pstate_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_e;

    typedef struct packed {
        logic clk_en;
        logic rst;
    } mod_drive_t;

    localparam int CTRL_LRST_BIT = 4;
    localparam int WORD_CMD      = 0;
    localparam int WORD_BUSY     = 1;
    localparam int WORD_CTRL0    = 2;

    function automatic mod_drive_t drive_of(input logic [1:0] st);
        mod_drive_t d;
        case (pstate_e'(st))
            PS_ON:      d = '{clk_en: 1'b1, rst: 1'b0};
            PS_OFF:     d = '{clk_en: 1'b0, rst: 1'b0};
            PS_RST_CLK: d = '{clk_en: 1'b1, rst: 1'b1};
            default:    d = '{clk_en: 1'b0, rst: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int N_MOD  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic                    busy,
    input  logic [N_MOD-1:0][1:0]   cur_state,
    output logic [N_MOD-1:0][1:0]   next_state,
    output logic [N_MOD-1:0]        lrst,
    output logic                    go_req
);

    localparam int WORD_STATE0 = WORD_CTRL0 + N_MOD;

    assign go_req = reg_wr && (reg_addr == ADDR_W'(WORD_CMD)) && reg_wdata[0];

    for (genvar g = 0; g < N_MOD; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                next_state[g] <= 2'd0;
                lrst[g]       <= 1'b0;
            end else if (reg_wr && (reg_addr == ADDR_W'(WORD_CTRL0 + g))) begin
                next_state[g] <= reg_wdata[1:0];
                lrst[g]       <= reg_wdata[CTRL_LRST_BIT];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(WORD_BUSY)) begin
            reg_rdata[0] = busy;
        end
        for (int i = 0; i < N_MOD; i++) begin
            if (reg_addr == ADDR_W'(WORD_CTRL0 + i)) begin
                reg_rdata[1:0]           = next_state[i];
                reg_rdata[CTRL_LRST_BIT] = lrst[i];
            end
            if (reg_addr == ADDR_W'(WORD_STATE0 + i)) begin
                reg_rdata[1:0] = cur_state[i];
            end
        end
    end

endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
    import pwr_seq_pkg::*;
#(
    parameter int N_MOD    = 4,
    parameter int XFER_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go_req,
    input  logic [N_MOD-1:0][1:0]   next_state,
    output logic                    busy,
    output logic [N_MOD-1:0][1:0]   cur_state,
    output logic [N_MOD-1:0][1:0]   tgt_state
);

    localparam int CNT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
    localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;

    seq_e              seq;
    logic [CNT_W-1:0]  cnt;
    logic [N_MOD-1:0]  pend;
    logic [IDX_W-1:0]  sel;
    logic              any_pend;

    for (genvar g = 0; g < N_MOD; g++) begin : g_pend
        assign pend[g] = (tgt_state[g] != cur_state[g]);
    end

    always_comb begin
        sel = '0;
        for (int i = N_MOD - 1; i >= 0; i--) begin
            if (pend[i]) sel = IDX_W'(i);
        end
    end

    assign any_pend = |pend;
    assign busy     = (seq == SQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq       <= SQ_IDLE;
            cnt       <= '0;
            cur_state <= '0;
            tgt_state <= '0;
        end else begin
            case (seq)
                SQ_IDLE: begin
                    if (go_req) begin
                        tgt_state <= next_state;
                        cnt       <= '0;
                        seq       <= SQ_RUN;
                    end
                end
                default: begin
                    if (!any_pend) begin
                        seq <= SQ_IDLE;
                    end else if (cnt == CNT_W'(XFER_CYC - 1)) begin
                        cur_state[sel] <= tgt_state[sel];
                        cnt            <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pwr_seq_outmap.sv
module pwr_seq_outmap
    import pwr_seq_pkg::*;
#(
    parameter int N_MOD = 4
) (
    input  logic [N_MOD-1:0][1:0] cur_state,
    output logic [N_MOD-1:0]      mod_clk_en,
    output logic [N_MOD-1:0]      mod_rst
);

    for (genvar g = 0; g < N_MOD; g++) begin : g_map
        mod_drive_t d;
        assign d             = drive_of(cur_state[g]);
        assign mod_clk_en[g] = d.clk_en;
        assign mod_rst[g]    = d.rst;
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int N_MOD    = 4,
    parameter int XFER_CYC = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_MOD-1:0]  mod_clk_en,
    output logic [N_MOD-1:0]  mod_rst,
    output logic [N_MOD-1:0]  mod_lrst
);

    logic                  busy;
    logic                  go_req;
    logic [N_MOD-1:0][1:0] next_state;
    logic [N_MOD-1:0][1:0] cur_state;
    logic [N_MOD-1:0][1:0] tgt_state;

    pwr_seq_regs #(
        .N_MOD (N_MOD),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .cur_state (cur_state),
        .next_state(next_state),
        .lrst      (mod_lrst),
        .go_req    (go_req)
    );

    pwr_seq_engine #(
        .N_MOD   (N_MOD),
        .XFER_CYC(XFER_CYC)
    ) engine_i (
        .clk       (clk),
        .rst       (rst),
        .go_req    (go_req),
        .next_state(next_state),
        .busy      (busy),
        .cur_state (cur_state),
        .tgt_state (tgt_state)
    );

    pwr_seq_outmap #(
        .N_MOD(N_MOD)
    ) outmap_i (
        .cur_state (cur_state),
        .mod_clk_en(mod_clk_en),
        .mod_rst   (mod_rst)
    );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
#(
    parameter int N_MOD  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic                  busy,
    input logic [N_MOD-1:0][1:0] cur_state,
    input logic [N_MOD-1:0][1:0] tgt_state
);

    logic [N_MOD-1:0][1:0] prev_state;
    logic [N_MOD-1:0]      chg;

    always_ff @(posedge clk) prev_state <= cur_state;

    always_comb begin
        for (int i = 0; i < N_MOD; i++) chg[i] = (prev_state[i] != cur_state[i]);
    end

    AST_GO_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(WORD_CMD) && reg_wdata[0] && !busy) |=> busy); // R4

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(cur_state)); // R2

    AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == ADDR_W'(WORD_CMD)) |=> $stable(tgt_state)); // R6

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg)); // R8

    AST_DONE_MATCHES: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cur_state == tgt_state)); // R5

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(WORD_CMD)) |-> (reg_rdata == '0)); // R12

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
    .N_MOD (N_MOD),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .cur_state(cur_state),
    .tgt_state(tgt_state)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;

    localparam int N   = 4;
    localparam int X   = 3;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int A_CMD  = 0;
    localparam int A_BUSY = 1;
    localparam int A_CTL  = 2;
    localparam int A_ST   = 2 + N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  mod_clk_en, mod_rst, mod_lrst;

    int checks = 0;
    int errors = 0;
    int exp_st [N];

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(.N_MOD(N), .XFER_CYC(X), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst(mod_rst), .mod_lrst(mod_lrst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    // outputs implied by a state, per R9: {clk_en, rst}
    function automatic int drv(input int st);
        case (st)
            3: return 2;
            2: return 0;
            1: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic chk_mod(input int i, input string req);
        int act;
        act = {30'd0, mod_clk_en[i], mod_rst[i]};
        chk(act == drv(exp_st[i]), req, act, drv(exp_st[i]));
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = AW'(A_BUSY);
        #1;
        while (reg_rdata[0] && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        int d;
        rd(A_BUSY, d); chk(d == 0, "R10 busy", d, 0);
        for (int i = 0; i < N; i++) begin
            rd(A_ST + i, d);  chk(d == 0, "R10 state", d, 0);
            rd(A_CTL + i, d); chk(d == 0, "R10 ctrl", d, 0);
            exp_st[i] = 0;
            chk_mod(i, "R9 reset outputs");
        end
        chk(mod_lrst == 0, "R10 lrst", int'(mod_lrst), 0);
    endtask

    task automatic t_staged;
        int d;
        wr(A_CTL + 1, 3);
        wr(A_CTL + 3, 2);
        repeat (10) @(posedge clk);
        for (int i = 0; i < N; i++) begin
            rd(A_ST + i, d); chk(d == 0, "R2 state held", d, 0);
            chk_mod(i, "R2 outputs held");
        end
        rd(A_CTL + 1, d); chk(d == 3, "R1 ctrl readback", d, 3);
    endtask

    task automatic t_commit_order;
        int d;
        wr(A_CMD, 1);
        reg_addr = AW'(A_BUSY); #0.5;
        chk(reg_rdata[0] == 1'b1, "R4 busy after go", int'(reg_rdata[0]), 1);
        repeat (X) @(posedge clk);
        #1;
        exp_st[1] = 3;
        chk_mod(1, "R8 first module moved");
        chk_mod(3, "R8 later module waits");
        repeat (X) @(posedge clk);
        #1;
        exp_st[3] = 2;
        chk_mod(3, "R8 second module moved");
        chk(reg_rdata[0] == 1'b1, "R5 busy held", int'(reg_rdata[0]), 1);
        @(posedge clk); #1;
        chk(reg_rdata[0] == 1'b0, "R8 busy length", int'(reg_rdata[0]), 0);
        for (int i = 0; i < N; i++) chk_mod(i, "R3 all applied");
        rd(A_ST + 1, d); chk(d == 3, "R1 state word", d, 3);
        rd(A_ST + 3, d); chk(d == 2, "R3 state word", d, 2);
        rd(A_CMD, d);    chk(d == 0, "R12 cmd reads 0", d, 0);
    endtask

    task automatic t_skip;
        int n;
        wr(A_CTL + 2, 1);
        wr(A_CMD, 1);
        wait_idle(n);
        chk(n == 1 + X, "R11 skip costs nothing", n, 1 + X);
        exp_st[2] = 1;
        chk_mod(2, "R9 clocked-in-reset");
        wr(A_CMD, 1);
        wait_idle(n);
        chk(n == 1, "R11 nothing pending", n, 1);
    endtask

    task automatic t_busy_ignore;
        int n, d;
        wr(A_CTL + 0, 3);
        wr(A_CMD, 1);
        wr(A_CTL + 2, 3);
        wr(A_CMD, 1);
        wait_idle(n);
        exp_st[0] = 3;
        chk_mod(0, "R6 first commit");
        chk_mod(2, "R6 busy target held back");
        rd(A_CTL + 2, d); chk(d == 3, "R6 staged readback", d, 3);
        wr(A_CMD, 1);
        wait_idle(n);
        exp_st[2] = 3;
        chk_mod(2, "R6 later commit applies");
    endtask

    task automatic t_lrst;
        int d;
        wr(A_CTL + 1, 16 + 0);
        chk(mod_lrst == 4'b0010, "R7 lrst asserted", int'(mod_lrst), 2);
        chk_mod(1, "R7 state untouched");
        rd(A_CTL + 1, d); chk(d == 16, "R7 readback", d, 16);
        wr(A_CTL + 1, 3);
        chk(mod_lrst == 4'b0000, "R7 lrst released", int'(mod_lrst), 0);
    endtask

    task automatic t_all_codes;
        int n, k;
        k = 0;
        for (int i = 0; i < N; i++) begin
            wr(A_CTL + i, i);
            if (exp_st[i] != i) k++;
        end
        wr(A_CMD, 1);
        wait_idle(n);
        chk(n == 1 + X * k, "R8 multi busy length", n, 1 + X * k);
        for (int i = 0; i < N; i++) begin
            exp_st[i] = i;
            chk_mod(i, "R1 R9 each encoding");
        end
    endtask

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_staged();
        t_commit_order();
        t_skip();
        t_busy_ignore();
        t_lrst();
        t_all_codes();
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule